// File: doc/BRIEF.md
# HDLC Receive Frame Length Limiter

This block sits behind the flag detector and bit de-stuffer of an HDLC receiver and enforces a programmable ceiling on the number of in-frame bytes. Three strobes drive it. One marks an opening flag. One marks each received byte. One marks a closing flag. Every byte between the two flags counts toward the frame length, whether it is address, control, payload or checksum.

At each opening flag a down-counter is loaded with the configured limit. Bytes are forwarded to buffer storage for as long as that budget lasts. The first byte beyond the budget marks the frame as oversized. That byte and every later byte of the frame are then withheld from storage. The block still counts those bytes, and at the closing flag it emits a single-cycle status word. The status word carries the total length, which saturates at the counter's maximum, and an oversize bit. Flag detection, de-stuffing and checksum verification are done elsewhere.

Top module: `hdlc_len_limiter`

## Requirements
- R1: In the cycle after a synchronous reset, `byte_out_vld`, `byte_out`, `rpt_vld`, `rpt_len` and `rpt_too_long` are all zero.
- R2: A byte strobe has no effect on any output or on the reported length in these cases: it arrives outside a frame (before the first opening flag, or after a closing flag), or it arrives in the same cycle as an opening or closing flag.
- R3: The byte budget is loaded from `cfg_max_len` only at an opening flag. A change to `cfg_max_len` during a frame has no effect on that frame.
- R4: With a limit of L, the first L bytes of a frame are forwarded one cycle after their strobe, with `byte_out_vld` high and `byte_out` equal to the received byte. A byte that arrives when exactly L-1 bytes have already been received is forwarded.
- R5: Byte L+1 of a frame, and every later byte of that frame, are dropped (`byte_out_vld` stays low). With L = 0, every byte is dropped.
- R6: A closing flag inside a frame raises `rpt_vld` for exactly one cycle, one cycle later. In that cycle `rpt_len` equals the number of counted bytes of the frame (forwarded plus dropped), and `rpt_too_long` is 1 exactly when that number exceeds L.
- R7: The reported length saturates at 0xFFFF and does not wrap.
- R8: A closing flag outside a frame produces no report. An opening flag inside a frame restarts counting and budget without reporting the abandoned frame.
- R9: When a closing flag and an opening flag arrive in the same cycle, the current frame is reported and a new frame opens with a fresh budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_max_len | input | 16 | Maximum allowed bytes per frame |
| sof_i | input | 1 | Opening flag seen |
| eof_i | input | 1 | Closing flag seen |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte value |
| byte_out_vld | output | 1 | Byte forwarded to storage |
| byte_out | output | 8 | Forwarded byte value |
| rpt_vld | output | 1 | Frame status valid (one cycle) |
| rpt_len | output | 16 | Total counted frame length |
| rpt_too_long | output | 1 | Frame exceeded the limit |

## Verification
The bench goes after the exact boundary, where byte L must pass and byte L+1 must not. An off-by-one budget would either forward one byte too many or flag a frame of exactly L bytes as too long. A zero limit is covered: a design that decrements below zero would wrap and start forwarding again. The bench also changes the limit in mid-frame, which catches a design that reads the live register. It sends a frame of more than 65535 bytes, which shows whether the length wraps to a small number instead of saturating. A closing flag shared with the next opening flag checks that the old frame is reported and the new budget is still loaded, not one event lost. Random frames with random gaps and limits fill in the ordinary mix.

// File: rtl/hdlc_len_pkg.sv
package hdlc_len_pkg;

  typedef enum logic [1:0] {
    BYTE_NONE = 2'd0,
    BYTE_KEEP = 2'd1,
    BYTE_DROP = 2'd2
  } byte_disp_e;

endpackage

// File: rtl/hdlc_len_budget.sv
module hdlc_len_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  AST_BUDGET_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero); // R5

endmodule

// File: rtl/hdlc_len_tally.sv
module hdlc_len_tally #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [LEN_W-1:0] len
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (clr) begin
      len_q <= '0;
    end else if (inc && (len_q != LEN_MAX)) begin
      len_q <= len_q + 1'b1;
    end
  end

  assign len = len_q;

  AST_LEN_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (len_q == LEN_MAX && !clr) |=> (len_q == LEN_MAX)); // R7

  AST_LEN_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (len_q >= $past(len_q))); // R7

endmodule

// File: rtl/hdlc_len_gate.sv
module hdlc_len_gate
  import hdlc_len_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sof,
  input  logic       eof,
  input  logic       vld,
  input  logic       budget_zero,
  output byte_disp_e disp,
  output logic       close,
  output logic       in_frame,
  output logic       over
);

  logic in_frame_q;
  logic over_q;
  logic take;

  assign take  = vld && in_frame_q && !sof && !eof;
  assign close = eof && in_frame_q;

  always_comb begin
    if (!take) begin
      disp = BYTE_NONE;
    end else if (!over_q && !budget_zero) begin
      disp = BYTE_KEEP;
    end else begin
      disp = BYTE_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      over_q     <= 1'b0;
    end else begin
      if (sof) begin
        in_frame_q <= 1'b1;
        over_q     <= 1'b0;
      end else begin
        if (eof) begin
          in_frame_q <= 1'b0;
        end
        if (disp == BYTE_DROP) begin
          over_q <= 1'b1;
        end
      end
    end
  end

  assign in_frame = in_frame_q;
  assign over     = over_q;

  AST_NO_KEEP_AFTER_OVER: assert property (@(posedge clk) disable iff (rst)
    (over_q && !sof) |-> (disp != BYTE_KEEP)); // R5

  AST_IDLE_NO_BYTES: assert property (@(posedge clk) disable iff (rst)
    !in_frame_q |-> (disp == BYTE_NONE)); // R2

endmodule

// File: rtl/hdlc_len_limiter.sv
module hdlc_len_limiter
  import hdlc_len_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              byte_out_vld,
  output logic [DATA_W-1:0] byte_out,
  output logic              rpt_vld,
  output logic [LEN_W-1:0]  rpt_len,
  output logic              rpt_too_long
);

  byte_disp_e       disp;
  logic             close;
  logic             in_frame;
  logic             over;
  logic             budget_zero;
  logic [LEN_W-1:0] len;

  hdlc_len_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .sof         (sof_i),
    .eof         (eof_i),
    .vld         (byte_vld_i),
    .budget_zero (budget_zero),
    .disp        (disp),
    .close       (close),
    .in_frame    (in_frame),
    .over        (over)
  );

  hdlc_len_budget #(.CNT_W(LEN_W)) u_budget (
    .clk      (clk),
    .rst      (rst),
    .load     (sof_i),
    .load_val (cfg_max_len),
    .dec      (disp == BYTE_KEEP),
    .zero     (budget_zero)
  );

  hdlc_len_tally #(.LEN_W(LEN_W)) u_tally (
    .clk (clk),
    .rst (rst),
    .clr (sof_i),
    .inc (disp != BYTE_NONE),
    .len (len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out_vld <= 1'b0;
      byte_out     <= '0;
      rpt_vld      <= 1'b0;
      rpt_len      <= '0;
      rpt_too_long <= 1'b0;
    end else begin
      byte_out_vld <= (disp == BYTE_KEEP);
      if (disp == BYTE_KEEP) begin
        byte_out <= byte_i;
      end
      rpt_vld <= close;
      if (close) begin
        rpt_len      <= len;
        rpt_too_long <= over;
      end
    end
  end

  AST_OUT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    !in_frame |=> !byte_out_vld); // R2

  AST_RPT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !eof_i |=> !rpt_vld); // R6

  AST_LONG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (rpt_vld && rpt_too_long) |-> (rpt_len != '0)); // R6

endmodule

// File: tb/hdlc_len_limiter_tb.sv
module hdlc_len_limiter_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cfg_max_len;
  logic        sof_i, eof_i, byte_vld_i;
  logic [7:0]  byte_i;
  logic        byte_out_vld;
  logic [7:0]  byte_out;
  logic        rpt_vld;
  logic [15:0] rpt_len;
  logic        rpt_too_long;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit          m_in     = 1'b0;
  bit          m_over   = 1'b0;
  int          m_budget = 0;
  logic [15:0] m_len    = '0;

  always #4 clk = ~clk;

  hdlc_len_limiter u_dut (
    .clk          (clk),
    .rst          (rst),
    .cfg_max_len  (cfg_max_len),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .byte_vld_i   (byte_vld_i),
    .byte_i       (byte_i),
    .byte_out_vld (byte_out_vld),
    .byte_out     (byte_out),
    .rpt_vld      (rpt_vld),
    .rpt_len      (rpt_len),
    .rpt_too_long (rpt_too_long)
  );

  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit e, input bit v, input logic [7:0] b,
                      input string tag, input bit check_all);
    bit          e_ov = 1'b0;
    logic [7:0]  e_ob = '0;
    bit          e_rv = 1'b0;
    logic [15:0] e_rl = '0;
    bit          e_rt = 1'b0;
    if (e && m_in) begin
      e_rv = 1'b1; e_rl = m_len; e_rt = m_over;
    end
    if (v && m_in && !s && !e) begin
      m_len = sat_inc(m_len);
      if (!m_over && m_budget != 0) begin
        e_ov = 1'b1; e_ob = b; m_budget--;
      end else begin
        m_over = 1'b1;
      end
    end
    if (s) begin
      m_in = 1'b1; m_budget = int'(cfg_max_len); m_len = '0; m_over = 1'b0;
    end else if (e) begin
      m_in = 1'b0;
    end
    sof_i = s; eof_i = e; byte_vld_i = v; byte_i = b;
    @(posedge clk); #1;
    sof_i = 1'b0; eof_i = 1'b0; byte_vld_i = 1'b0;
    if (check_all || e_ov || byte_out_vld)
      chk(tag, "byte_out_vld", int'(byte_out_vld), int'(e_ov));
    if (e_ov) chk(tag, "byte_out", int'(byte_out), int'(e_ob));
    if (check_all || e_rv || rpt_vld)
      chk(tag, "rpt_vld", int'(rpt_vld), int'(e_rv));
    if (e_rv) begin
      chk(tag, "rpt_len", int'(rpt_len), int'(e_rl));
      chk(tag, "rpt_too_long", int'(rpt_too_long), int'(e_rt));
    end
  endtask

  task automatic frame(input int lim, input int nbytes, input string tag);
    cfg_max_len = lim[15:0];
    step(1'b1, 1'b0, 1'b0, 8'h00, tag, 1'b1);
    for (int i = 0; i < nbytes; i++) step(1'b0, 1'b0, 1'b1, 8'(i * 7 + 3), tag, 1'b1);
    step(1'b0, 1'b1, 1'b0, 8'h00, tag, 1'b1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2718));
    rst = 1'b1; cfg_max_len = 16'd4;
    sof_i = 1'b0; eof_i = 1'b0; byte_vld_i = 1'b0; byte_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "byte_out_vld", int'(byte_out_vld), 0);
    chk("R1", "byte_out", int'(byte_out), 0);
    chk("R1", "rpt_vld", int'(rpt_vld), 0);
    chk("R1", "rpt_len", int'(rpt_len), 0);
    chk("R1", "rpt_too_long", int'(rpt_too_long), 0);
    rst = 1'b0;

    // R2: bytes and a closing flag before any frame
    step(1'b0, 1'b0, 1'b1, 8'hA5, "R2", 1'b1);
    step(1'b0, 1'b1, 1'b0, 8'h00, "R8", 1'b1);
    // R4: exact boundary, L bytes all forwarded, not too long
    frame(4, 4, "R4");
    // R5: overflow by two
    frame(4, 6, "R5");
    // R5: zero limit, bytes and empty frame
    frame(0, 2, "R5");
    frame(0, 0, "R6");
    frame(1, 0, "R6");
    // R2: byte after closing flag, byte on opening/closing cycle
    step(1'b0, 1'b0, 1'b1, 8'h11, "R2", 1'b1);
    cfg_max_len = 16'd3;
    step(1'b1, 1'b0, 1'b1, 8'h22, "R2", 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h33, "R2", 1'b1);
    step(1'b0, 1'b1, 1'b1, 8'h44, "R2", 1'b1);
    // R3: limit changes mid-frame
    cfg_max_len = 16'd2;
    step(1'b1, 1'b0, 1'b0, 8'h00, "R3", 1'b1);
    cfg_max_len = 16'd9;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 8'(8'h50 + i), "R3", 1'b1);
    step(1'b0, 1'b1, 1'b0, 8'h00, "R3", 1'b1);
    // R8: restart mid-frame, no report
    cfg_max_len = 16'd1;
    step(1'b1, 1'b0, 1'b0, 8'h00, "R8", 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h61, "R8", 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h62, "R8", 1'b1);
    cfg_max_len = 16'd2;
    step(1'b1, 1'b0, 1'b0, 8'h00, "R8", 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h63, "R8", 1'b1);
    // R9: shared closing/opening flag
    cfg_max_len = 16'd1;
    step(1'b1, 1'b1, 1'b0, 8'h00, "R9", 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h71, "R9", 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h72, "R9", 1'b1);
    step(1'b0, 1'b1, 1'b0, 8'h00, "R9", 1'b1);
    // R7: very long frame saturates
    cfg_max_len = 16'd10;
    step(1'b1, 1'b0, 1'b0, 8'h00, "R7", 1'b1);
    for (int i = 0; i < 65540; i++) step(1'b0, 1'b0, 1'b1, 8'(i), "R7", 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'h00, "R7", 1'b1);
    // random mix (R4 R5 R6)
    for (int f = 0; f < 300; f++) begin
      cfg_max_len = 16'($urandom_range(0, 30));
      step(1'b1, 1'b0, 1'b0, 8'h00, "R6", 1'b1);
      for (int i = 0; i < int'($urandom_range(0, 40)); i++) begin
        if ($urandom_range(0, 3) == 0) step(1'b0, 1'b0, 1'b0, 8'h00, "R4", 1'b1);
        step(1'b0, 1'b0, 1'b1, 8'($urandom), "R5", 1'b1);
      end
      step(1'b0, 1'b1, 1'b0, 8'h00, "R6", 1'b1);
      if ($urandom_range(0, 1) == 1) step(1'b0, 1'b0, 1'b1, 8'h5A, "R2", 1'b1);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule